// File: doc/BRIEF.md
# Thumbwheel Frequency Dial Scanner

This block reads a six-digit decimal frequency setting from a bank of BCD thumbwheel switches. It raises one strobe line at a time. It waits a fixed settle interval and takes the selected switch's 4-bit code from a return bus that all six switches share. It then holds the strobe for a second settle interval before moving to the next digit.

Once all six digits are held, a small sequential converter builds the binary value one digit per clock. It starts at the most significant digit and, at each step, multiplies the running value by ten and adds the next digit. The binary result is halved, because one unit of the output word stands for 2 Hz. The block registers the halved value as a 16-bit frequency word and announces it with a one-cycle valid pulse. A range flag is set when the setting is unusable.

After each result the block waits for a fixed pause and then scans again, without end. A downstream synthesizer loads the word whenever the valid pulse is seen.

Top module: `dial_freq_scanner`

## Requirements
- R1: At most one bit of `strobe_o` is high in any cycle. All strobes are low while the block converts and while it pauses.
- R2: Strobes become active in the order bit 0, 1, 2, 3, 4, 5, one directly after another. Each one stays high for exactly 2*SETTLE_CYCLES consecutive cycles.
- R3: The return bus `digit_i` is sampled only in the SETTLE_CYCLES-th cycle of a strobe's active period. Its value in every other cycle has no effect on the result.
- R4: Digit n (read under strobe bit n) carries decimal weight 10^n. The decimal value V is built by Horner's scheme from digit 5 down to digit 0. The output word is floor(V/2), truncated to its low 16 bits. A digit code above 9 enters the sum with its raw binary value.
- R5: `word_valid_o` is high for exactly one cycle per scan. `freq_word_o` and `range_err_o` change only in a cycle where `word_valid_o` is high.
- R6: `range_err_o` is 1 when V < MIN_VALUE (default 10), when V > MAX_VALUE (default 100000), or when any digit code exceeds 9. Otherwise it is 0.
- R7: Strobe bit 0 becomes active again exactly IDLE_CYCLES cycles after the cycle in which `word_valid_o` is high.
- R8: After strobe bit 5 drops, exactly DIGITS+2 (default 8) cycles with no strobe pass before the cycle that carries `word_valid_o`.
- R9: In the first cycle after synchronous reset, `freq_word_o` is 0, `word_valid_o` is 0, `range_err_o` is 0, and strobe bit 0 is already active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_o | output | 6 | One-hot digit select driven to the switch commons |
| digit_i | input | 4 | Shared BCD return bus from the selected switch |
| freq_word_o | output | 16 | Frequency setting in 2 Hz units |
| word_valid_o | output | 1 | One-cycle pulse marking a new word |
| range_err_o | output | 1 | Setting outside the supported range, or a non-decimal digit |

## Verification
The assertions assume that the switch bank answers only on the return bus and never drives the strobe lines. They also take reset as held for at least one clock edge before checks begin. No property depends on what `digit_i` carries, because the design has to tolerate an arbitrary value on the bus outside its sampling cycle. The stimulus model drives a random wrong code in every cycle except the one where sampling is required. It changes the dialled setting only in the valid cycle, which lies inside the idle pause, so each scan sees one consistent setting. Directed settings cover the range edges, an odd value, all zeros, all nines and codes above 9. Random settings mix mostly legal digits with occasional illegal ones.

// File: rtl/dial_scan_pkg.sv
package dial_scan_pkg;

    localparam int DIGITS = 6;
    localparam int NIB_W  = 4;
    localparam int BCD_W  = DIGITS * NIB_W;
    localparam int ACC_W  = BCD_W;
    localparam int IDX_W  = $clog2(DIGITS);

    typedef enum logic [1:0] {
        SEQ_PRE,
        SEQ_POST,
        SEQ_WAIT
    } seq_state_e;

    // One Horner step: acc*10 + nib, built from two shifts.
    function automatic logic [ACC_W-1:0] times_ten_plus(
        input logic [ACC_W-1:0] acc,
        input logic [NIB_W-1:0] nib
    );
        return (acc << 3) + (acc << 1) + ACC_W'(nib);
    endfunction

    function automatic logic has_bad_nibble(input logic [BCD_W-1:0] bcd);
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < DIGITS; i++) begin
            if (bcd[i*NIB_W +: NIB_W] > 4'd9) bad = 1'b1;
        end
        return bad;
    endfunction

endpackage

// File: rtl/dial_strobe_seq.sv
module dial_strobe_seq
    import dial_scan_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [NIB_W-1:0]  digit_i,
    output logic [DIGITS-1:0] strobe_o,
    output logic [BCD_W-1:0]  bcd_o,
    output logic              scan_done_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIGITS - 1);

    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [BCD_W-1:0] bcd_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_PRE;
            idx_q   <= '0;
            cnt_q   <= '0;
            bcd_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_PRE: begin
                    if (cnt_q == CNT_LAST) begin
                        bcd_q[idx_q*NIB_W +: NIB_W] <= digit_i;
                        cnt_q   <= '0;
                        state_q <= SEQ_POST;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_POST: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_q <= '0;
                        if (idx_q == IDX_LAST) begin
                            idx_q   <= '0;
                            state_q <= SEQ_WAIT;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= SEQ_PRE;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (start_i) state_q <= SEQ_PRE;
                end
            endcase
        end
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_strobe
        assign strobe_o[g] = (state_q != SEQ_WAIT) && (idx_q == IDX_W'(g));
    end

    assign bcd_o       = bcd_q;
    assign scan_done_o = done_q;

endmodule

// File: rtl/bcd_horner_conv.sv
module bcd_horner_conv
    import dial_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [BCD_W-1:0] bcd_i,
    output logic [ACC_W-1:0] value_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIGITS - 1);

    logic             busy_q;
    logic [IDX_W-1:0] k_q;
    logic [ACC_W-1:0] acc_q;
    logic             done_q;
    logic [IDX_W-1:0] pos;
    logic [NIB_W-1:0] nib;

    // Most significant digit first.
    assign pos = IDX_LAST - k_q;
    assign nib = bcd_i[pos*NIB_W +: NIB_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            k_q    <= '0;
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                busy_q <= 1'b1;
                k_q    <= '0;
                acc_q  <= '0;
            end else if (busy_q) begin
                acc_q <= times_ten_plus(acc_q, nib);
                if (k_q == IDX_LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    k_q <= k_q + 1'b1;
                end
            end
        end
    end

    assign value_o = acc_q;
    assign done_o  = done_q;

endmodule

// File: rtl/dial_freq_scanner.sv
module dial_freq_scanner
    import dial_scan_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4,
    parameter int IDLE_CYCLES   = 64,
    parameter int MIN_VALUE     = 10,
    parameter int MAX_VALUE     = 100000,
    parameter int WORD_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [5:0]        strobe_o,
    input  logic [3:0]        digit_i,
    output logic [WORD_W-1:0] freq_word_o,
    output logic              word_valid_o,
    output logic              range_err_o
);
    localparam int IDL_W = $clog2(IDLE_CYCLES + 1);

    logic [BCD_W-1:0] bcd;
    logic             scan_done;
    logic [ACC_W-1:0] value;
    logic             conv_done;
    logic             restart;
    logic [IDL_W-1:0] idle_q;
    logic             bad_range;

    dial_strobe_seq #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (restart),
        .digit_i    (digit_i),
        .strobe_o   (strobe_o),
        .bcd_o      (bcd),
        .scan_done_o(scan_done)
    );

    bcd_horner_conv conv_i (
        .clk    (clk),
        .rst    (rst),
        .start_i(scan_done),
        .bcd_i  (bcd),
        .value_o(value),
        .done_o (conv_done)
    );

    assign bad_range = (value < ACC_W'(MIN_VALUE)) || (value > ACC_W'(MAX_VALUE))
                     || has_bad_nibble(bcd);
    assign restart   = (idle_q == IDL_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_word_o  <= '0;
            word_valid_o <= 1'b0;
            range_err_o  <= 1'b0;
            idle_q       <= '0;
        end else begin
            word_valid_o <= 1'b0;
            if (conv_done) begin
                freq_word_o  <= value[WORD_W:1];
                word_valid_o <= 1'b1;
                range_err_o  <= bad_range;
                idle_q       <= IDL_W'(IDLE_CYCLES);
            end else if (idle_q != '0) begin
                idle_q <= idle_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dial_freq_scanner_chk.sv
module dial_freq_scanner_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [5:0]        strobe_o,
    input logic [WORD_W-1:0] freq_word_o,
    input logic              word_valid_o,
    input logic              range_err_o
);
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o)); // R1

    AST_STROBE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (strobe_o != 6'd0 && $past(strobe_o) != 6'd0 && strobe_o != $past(strobe_o))
        |-> (strobe_o == ($past(strobe_o) << 1))); // R2

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o); // R5

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !word_valid_o |-> ($stable(freq_word_o) && $stable(range_err_o))); // R5

    AST_NO_STROBE_AT_VALID: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> (strobe_o == 6'd0)); // R8

endmodule

bind dial_freq_scanner dial_freq_scanner_chk #(.WORD_W(WORD_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .strobe_o    (strobe_o),
    .freq_word_o (freq_word_o),
    .word_valid_o(word_valid_o),
    .range_err_o (range_err_o)
);

// File: tb/dial_freq_scanner_tb_top.sv
`timescale 1ns/1ps
module dial_freq_scanner_tb_top;
    localparam int S     = 3;
    localparam int IDLE  = 20;
    localparam int D     = 6;
    localparam int NRUN  = 80;
    localparam int LIMIT = 50000;
    localparam int NDIR  = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  strobe;
    logic [3:0]  digit = 4'h0;
    logic [15:0] word;
    logic        valid;
    logic        err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int nwords = 0;
    int k = 0, zc = 0, gap = 0;
    logic        after_valid = 1'b0;
    logic        prev_valid  = 1'b0;
    logic [5:0]  prev = 6'd0;
    logic [15:0] prev_word = 16'd0;
    logic        prev_err  = 1'b0;
    logic [23:0] dial;

    logic [23:0] dir [NDIR] = '{24'h000010, 24'h000009, 24'h100000, 24'h100001,
                                24'h999999, 24'h000000, 24'h012345, 24'h0A0050,
                                24'h000011, 24'h05F000};

    always #2 clk = ~clk;

    dial_freq_scanner #(.SETTLE_CYCLES(S), .IDLE_CYCLES(IDLE)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .strobe_o    (strobe),
        .digit_i     (digit),
        .freq_word_o (word),
        .word_valid_o(valid),
        .range_err_o (err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int dial_value(input logic [23:0] v);
        int acc = 0;
        for (int i = 5; i >= 0; i--) acc = acc * 10 + int'(v[4*i +: 4]);
        return acc;
    endfunction

    function automatic bit dial_err(input logic [23:0] v);
        int n = dial_value(v);
        bit bad = (n < 10) || (n > 100000);
        for (int i = 0; i < 6; i++) if (v[4*i +: 4] > 4'd9) bad = 1'b1;
        return bad;
    endfunction

    function automatic logic [23:0] next_dial(input int n);
        logic [23:0] v;
        if (n < NDIR) return dir[n];
        for (int i = 0; i < 6; i++) begin
            if ($urandom_range(0, 99) < 5) v[4*i +: 4] = 4'($urandom_range(10, 15));
            else v[4*i +: 4] = 4'($urandom_range(0, 9));
        end
        return v;
    endfunction

    function automatic int strobe_idx(input logic [5:0] s);
        int r = 0;
        for (int i = 0; i < 6; i++) if (s[i]) r = i;
        return r;
    endfunction

    // Switch-bank model and monitor, all on the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            k = 0; zc = 0; after_valid = 1'b0; prev_valid = 1'b0;
            prev = strobe; prev_word = word; prev_err = err;
        end else begin
            if (after_valid) gap++;
            chk($onehot0(strobe), "R1", "strobe one-hot", longint'(strobe), 0);
            if (strobe != 6'd0) begin
                if (prev == 6'd0) begin
                    if (after_valid) chk(gap == IDLE, "R7", "idle gap", gap, IDLE);
                    after_valid = 1'b0;
                    chk(strobe == 6'd1, "R2", "first strobe", longint'(strobe), 1);
                    k = 1;
                end else if (strobe == prev) begin
                    k++;
                end else begin
                    chk(k == 2*S, "R2", "strobe length", k, 2*S);
                    chk(strobe == (prev << 1), "R2", "strobe order",
                        longint'(strobe), longint'(prev << 1));
                    k = 1;
                end
                zc = 0;
                // R3: the correct code is present only in the S-th active cycle
                if (k == S) digit = dial[4*strobe_idx(strobe) +: 4];
                else digit = dial[4*strobe_idx(strobe) +: 4] + 4'($urandom_range(1, 15));
            end else begin
                if (prev != 6'd0) chk(k == 2*S, "R2", "last strobe length", k, 2*S);
                digit = 4'($urandom);
                if (valid) begin
                    chk(zc == D + 2, "R8", "off cycles before valid", zc, D + 2);
                    chk(word == 16'(dial_value(dial) >> 1), "R3,R4", "freq word",
                        word, longint'(16'(dial_value(dial) >> 1)));
                    chk(err == dial_err(dial), "R6", "range flag", err, dial_err(dial));
                    after_valid = 1'b1;
                    gap = 0;
                    nwords++;
                    dial = next_dial(nwords);
                end
                zc++;
            end
            if (valid) chk(!prev_valid, "R5", "valid width", 1, 0);
            else chk(word == prev_word && err == prev_err, "R5", "outputs held",
                     longint'({word, err}), longint'({prev_word, prev_err}));
            prev = strobe; prev_valid = valid; prev_word = word; prev_err = err;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        dial = dir[0];
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #1;
        chk(word == 16'd0 && !valid && !err, "R9", "outputs after reset",
            longint'({word, valid, err}), 0);
        chk(strobe == 6'd1, "R9", "strobe after reset", longint'(strobe), 1);
        while (nwords < NRUN && cyc < LIMIT) @(negedge clk);
        if (cyc >= LIMIT) chk(1'b0, "watchdog", "words seen", nwords, NRUN);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule